// File: doc/BRIEF.md
# Branch and Skip Condition Unit

This block decides where an 8-bit core goes next after a control-flow instruction. It receives the current word address, an offset field, the status byte, an operation code and the operands of a skip test. From these it works out the next program counter, how many execution cycles the instruction costs, and whether the flow left the sequential path.

It covers three families of operation. The first is relative branches that test one status bit for set or clear, including named signed and unsigned comparisons. The second is an unconditional relative jump with a wider offset. The third is skip tests that compare two registers or look at one bit of a register or of an I/O value. A skip passes over the following instruction, so the decoder must say whether that instruction occupies one word or two.

A request is presented with `in_valid`. The result is registered and appears one clock later. Fetch and decode stay outside the block.

Top module: `branch_skip_unit`

## Requirements
- R1: While `rst` is high and in every cycle after reset with no request, `out_valid`, `taken`, `next_pc` and `cycles` are all zero. A request sampled with `in_valid` high at a rising edge produces `out_valid` high, with its result, right after that edge.
- R2: Operation code 0, and the unused codes 13 to 15, give `next_pc = pc + 1`, `cycles = 1` and `taken = 0`, whatever the other inputs are.
- R3: Code 1 branches when `status[bit_sel]` is 1, and code 2 branches when it is 0. A taken branch gives `next_pc = pc + sext(ofs[6:0]) + 1` and `cycles = 2`. A branch that is not taken gives `pc + 1` and `cycles = 1`.
- R4: Code 3 (signed greater or equal) branches when `status[2] XOR status[3]` is 0, where status bit 2 is the negative flag and bit 3 is the overflow flag. Code 4 (signed less than) branches when that XOR is 1.
- R5: Code 5 (unsigned same or higher) branches when the carry flag `status[0]` is 0. Code 6 (unsigned lower) branches when it is 1.
- R6: Code 7 is an unconditional jump. It gives `next_pc = pc + sext(ofs[11:0]) + 1`, `cycles = 2` and `taken = 1`.
- R7: For codes 1 to 6, only `ofs[6:0]` is used. Bits 11..7 of `ofs` have no effect on the target.
- R8: Code 8 skips when `reg_a == reg_b`.
- R9: Code 9 skips when `reg_a[bit_sel]` is 0, and code 10 skips when it is 1.
- R10: Code 11 skips when `io_val[bit_sel]` is 0, and code 12 skips when it is 1. Register operands play no part in these two tests.
- R11: A skip that fires gives `pc + 2` with `cycles = 2` when `next_long` is 0, and `pc + 3` with `cycles = 3` when `next_long` is 1. A skip that does not fire gives `pc + 1` and `cycles = 1`, whatever `next_long` is.
- R12: All address arithmetic wraps modulo 2^12.
- R13: While `out_valid` is high, `taken` is 1 exactly when `cycles` is greater than 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code (see requirements) |
| pc | input | 12 | Word address of the current instruction |
| ofs | input | 12 | Offset field, two's complement |
| status | input | 8 | Status byte (bit 0 carry, bit 2 negative, bit 3 overflow) |
| bit_sel | input | 3 | Bit index for status, register and I/O tests |
| reg_a | input | 8 | First register operand of a skip test |
| reg_b | input | 8 | Second register operand for the equality skip |
| io_val | input | 8 | I/O register value for the I/O bit skips |
| next_long | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | Result valid |
| next_pc | output | 12 | Next program counter |
| cycles | output | 2 | Execution cycles, 1 to 3 |
| taken | output | 1 | Flow left the sequential path |

## Verification
The clocked checks assume that each result refers to the request presented one cycle earlier. For that reason, `pc` must hold a meaningful value whenever `in_valid` is high. The stimulus drives a full, defined set of inputs with every request and holds them stable across the sampling edge. It also clears `in_valid` between requests, so each result can be tied to a single set of inputs. Unused operation codes are driven on purpose only, with inputs chosen so that any mistaken decode would be visible as a change in address.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_BR_SET = 4'd1,
    OP_BR_CLR = 4'd2,
    OP_BR_GE  = 4'd3,
    OP_BR_LT  = 4'd4,
    OP_BR_SH  = 4'd5,
    OP_BR_LO  = 4'd6,
    OP_JMP    = 4'd7,
    OP_SK_EQ  = 4'd8,
    OP_SK_RBC = 4'd9,
    OP_SK_RBS = 4'd10,
    OP_SK_IOC = 4'd11,
    OP_SK_IOS = 4'd12
  } bsu_op_e;

  typedef enum logic [1:0] {
    K_SEQ,
    K_REL_SHORT,
    K_REL_LONG,
    K_SKIP
  } bsu_kind_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
endpackage

// File: rtl/bsu_cond_eval.sv
module bsu_cond_eval
  import bsu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] status,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [DATA_W-1:0] io_val,
  output logic              fire,
  output bsu_kind_e         kind
);
  logic sel_flag, sel_reg, sel_io, signed_lt;

  assign sel_flag  = status[bit_sel];
  assign sel_reg   = reg_a[bit_sel];
  assign sel_io    = io_val[bit_sel];
  assign signed_lt = status[FLAG_N] ^ status[FLAG_V];

  always_comb begin
    fire = 1'b0;
    kind = K_SEQ;
    case (bsu_op_e'(op))
      OP_BR_SET: begin kind = K_REL_SHORT; fire = sel_flag;        end
      OP_BR_CLR: begin kind = K_REL_SHORT; fire = !sel_flag;       end
      OP_BR_GE:  begin kind = K_REL_SHORT; fire = !signed_lt;      end
      OP_BR_LT:  begin kind = K_REL_SHORT; fire = signed_lt;       end
      OP_BR_SH:  begin kind = K_REL_SHORT; fire = !status[FLAG_C]; end
      OP_BR_LO:  begin kind = K_REL_SHORT; fire = status[FLAG_C];  end
      OP_JMP:    begin kind = K_REL_LONG;  fire = 1'b1;            end
      OP_SK_EQ:  begin kind = K_SKIP;      fire = (reg_a == reg_b); end
      OP_SK_RBC: begin kind = K_SKIP;      fire = !sel_reg;        end
      OP_SK_RBS: begin kind = K_SKIP;      fire = sel_reg;         end
      OP_SK_IOC: begin kind = K_SKIP;      fire = !sel_io;         end
      OP_SK_IOS: begin kind = K_SKIP;      fire = sel_io;          end
      default:   begin kind = K_SEQ;       fire = 1'b0;            end
    endcase
  end
endmodule

// File: rtl/bsu_target_calc.sv
module bsu_target_calc
  import bsu_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int BOFS_W = 7,
  parameter int JOFS_W = 12
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [JOFS_W-1:0] ofs,
  input  bsu_kind_e         kind,
  input  logic              fire,
  input  logic              next_long,
  output logic [PC_W-1:0]   npc,
  output logic [1:0]        cycles,
  output logic              taken
);
  logic [PC_W-1:0] br_ext, jmp_ext, pc_inc;

  generate
    if (BOFS_W < PC_W) begin : g_br_ext
      assign br_ext = {{(PC_W-BOFS_W){ofs[BOFS_W-1]}}, ofs[BOFS_W-1:0]};
    end else begin : g_br_trunc
      assign br_ext = ofs[PC_W-1:0];
    end
    if (JOFS_W < PC_W) begin : g_jmp_ext
      assign jmp_ext = {{(PC_W-JOFS_W){ofs[JOFS_W-1]}}, ofs};
    end else begin : g_jmp_trunc
      assign jmp_ext = ofs[PC_W-1:0];
    end
  endgenerate

  assign pc_inc = pc + PC_W'(1);

  always_comb begin
    npc    = pc_inc;
    cycles = 2'd1;
    taken  = 1'b0;
    case (kind)
      K_REL_SHORT: if (fire) begin
        npc = pc_inc + br_ext; cycles = 2'd2; taken = 1'b1;
      end
      K_REL_LONG: begin
        npc = pc_inc + jmp_ext; cycles = 2'd2; taken = 1'b1;
      end
      K_SKIP: if (fire) begin
        taken = 1'b1;
        if (next_long) begin npc = pc + PC_W'(3); cycles = 2'd3; end
        else           begin npc = pc + PC_W'(2); cycles = 2'd2; end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsu_result_reg.sv
module bsu_result_reg #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [PC_W-1:0] npc_d,
  input  logic [1:0]      cycles_d,
  input  logic            taken_d,
  output logic            out_valid,
  output logic [PC_W-1:0] next_pc,
  output logic [1:0]      cycles,
  output logic            taken
);
  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      cycles    <= 2'd0;
      taken     <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      next_pc   <= npc_d;
      cycles    <= cycles_d;
      taken     <= taken_d;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !taken && cycles == 2'd0));

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import bsu_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DATA_W = 8,
  parameter int BOFS_W = 7,
  parameter int JOFS_W = 12,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [PC_W-1:0]   pc,
  input  logic [JOFS_W-1:0] ofs,
  input  logic [DATA_W-1:0] status,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [DATA_W-1:0] io_val,
  input  logic              next_long,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic [1:0]        cycles,
  output logic              taken
);
  logic            fire;
  bsu_kind_e       kind;
  logic [PC_W-1:0] npc_d;
  logic [1:0]      cycles_d;
  logic            taken_d;

  bsu_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .op(op), .status(status), .bit_sel(bit_sel), .reg_a(reg_a),
    .reg_b(reg_b), .io_val(io_val), .fire(fire), .kind(kind)
  );

  bsu_target_calc #(.PC_W(PC_W), .BOFS_W(BOFS_W), .JOFS_W(JOFS_W)) u_tgt (
    .pc(pc), .ofs(ofs), .kind(kind), .fire(fire), .next_long(next_long),
    .npc(npc_d), .cycles(cycles_d), .taken(taken_d)
  );

  bsu_result_reg #(.PC_W(PC_W)) u_reg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .npc_d(npc_d),
    .cycles_d(cycles_d), .taken_d(taken_d), .out_valid(out_valid),
    .next_pc(next_pc), .cycles(cycles), .taken(taken)
  );

  assert_cycles_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cycles != 2'd0);

  assert_sequential_step_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cycles == 2'd1) |-> next_pc == PC_W'($past(pc) + PC_W'(1)));

  assert_long_skip_step_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cycles == 2'd3) |-> next_pc == PC_W'($past(pc) + PC_W'(3)));

  assert_taken_matches_cost_R13: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (taken == (cycles != 2'd1)));
endmodule

// File: tb/sim_branch_skip_unit.sv
module sim_branch_skip_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [11:0] pc, ofs;
  logic [7:0]  status, reg_a, reg_b, io_val;
  logic [2:0]  bit_sel;
  logic        next_long;
  logic        out_valid, taken;
  logic [11:0] next_pc;
  logic [1:0]  cycles;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_skip_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pc(pc), .ofs(ofs),
    .status(status), .bit_sel(bit_sel), .reg_a(reg_a), .reg_b(reg_b),
    .io_val(io_val), .next_long(next_long), .out_valid(out_valid),
    .next_pc(next_pc), .cycles(cycles), .taken(taken)
  );

  task automatic clear_inputs();
    in_valid = 0; op = 0; pc = 0; ofs = 0; status = 0; bit_sel = 0;
    reg_a = 0; reg_b = 0; io_val = 0; next_long = 0;
  endtask

  task automatic check(string req, logic v, logic [11:0] npc, logic [1:0] cyc, logic tk,
                       logic ev, logic [11:0] enpc, logic [1:0] ecyc, logic etk);
    vectors++;
    if (v !== ev || npc !== enpc || cyc !== ecyc || tk !== etk) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b pc=%0d cyc=%0d taken=%0b, expected valid=%0b pc=%0d cyc=%0d taken=%0b",
               req, v, npc, cyc, tk, ev, enpc, ecyc, etk);
    end
  endtask

  // Drive one request at a falling edge, sample the registered result after the next rising edge.
  task automatic apply(string req, logic [3:0] o, logic [11:0] p, logic [11:0] f,
                       logic [7:0] st, logic [2:0] bs, logic [7:0] a, logic [7:0] b,
                       logic [7:0] io, logic lg, logic [11:0] enpc, logic [1:0] ecyc);
    @(negedge clk);
    in_valid = 1; op = o; pc = p; ofs = f; status = st; bit_sel = bs;
    reg_a = a; reg_b = b; io_val = io; next_long = lg;
    @(negedge clk);
    in_valid = 0;
    check(req, out_valid, next_pc, cycles, taken, 1'b1, enpc, ecyc, ecyc != 2'd1);
  endtask

  task automatic t_reset();
    rst = 1; clear_inputs();
    in_valid = 1; op = 4'd7; ofs = 12'd20;
    repeat (3) @(negedge clk);
    check("R1 reset", out_valid, next_pc, cycles, taken, 0, 0, 0, 0);
    rst = 0; in_valid = 0;
    @(negedge clk);
    check("R1 idle", out_valid, next_pc, cycles, taken, 0, 0, 0, 0);
  endtask

  task automatic t_sequential();
    apply("R2 op0", 4'd0, 12'd100, 12'd50, 8'hFF, 0, 8'h5, 8'h5, 0, 1, 12'd101, 1);
    apply("R2 op13", 4'd13, 12'd200, 12'd50, 8'hFF, 0, 8'h5, 8'h5, 8'hFF, 1, 12'd201, 1);
    apply("R2 op15", 4'd15, 12'd300, 12'd50, 8'h00, 0, 8'h0, 8'h0, 8'h0, 0, 12'd301, 1);
  endtask

  task automatic t_bit_branch();
    apply("R3 set taken", 4'd1, 12'd100, 12'h010, 8'b0010_0000, 3'd5, 0, 1, 0, 0, 12'd117, 2);
    apply("R3 set not", 4'd1, 12'd100, 12'h010, 8'b1101_1111, 3'd5, 0, 1, 0, 0, 12'd101, 1);
    apply("R3 clr taken", 4'd2, 12'd100, 12'h07F, 8'b1111_1101, 3'd1, 0, 1, 0, 0, 12'd100, 2);
    apply("R3 clr not", 4'd2, 12'd100, 12'h07F, 8'b0000_0010, 3'd1, 0, 1, 0, 0, 12'd101, 1);
  endtask

  task automatic t_signed();
    apply("R4 ge N=V=1", 4'd3, 12'd50, 12'd4, 8'b0000_1100, 0, 0, 1, 0, 0, 12'd55, 2);
    apply("R4 ge N^V", 4'd3, 12'd50, 12'd4, 8'b0000_0100, 0, 0, 1, 0, 0, 12'd51, 1);
    apply("R4 lt V only", 4'd4, 12'd50, 12'd4, 8'b0000_1000, 0, 0, 1, 0, 0, 12'd55, 2);
    apply("R4 lt N=V=0", 4'd4, 12'd50, 12'd4, 8'b1111_0011, 0, 0, 1, 0, 0, 12'd51, 1);
  endtask

  task automatic t_unsigned();
    apply("R5 sh C=0", 4'd5, 12'd60, 12'd3, 8'hFE, 0, 0, 1, 0, 0, 12'd64, 2);
    apply("R5 sh C=1", 4'd5, 12'd60, 12'd3, 8'h01, 0, 0, 1, 0, 0, 12'd61, 1);
    apply("R5 lo C=1", 4'd6, 12'd60, 12'd3, 8'h01, 0, 0, 1, 0, 0, 12'd64, 2);
    apply("R5 lo C=0", 4'd6, 12'd60, 12'd3, 8'hFE, 0, 0, 1, 0, 0, 12'd61, 1);
  endtask

  task automatic t_jump();
    apply("R6 fwd", 4'd7, 12'd1000, 12'd500, 0, 0, 0, 1, 0, 0, 12'd1501, 2);
    apply("R6 back", 4'd7, 12'd1000, 12'hC00, 0, 0, 0, 1, 0, 0, 12'd1000 + 12'hC00 + 12'd1, 2);
  endtask

  task automatic t_offset_mask();
    // ofs 0xF85: low seven bits are +5, the full field would be -123
    apply("R7 upper ignored", 4'd1, 12'd100, 12'hF85, 8'h01, 3'd0, 0, 1, 0, 0, 12'd106, 2);
    apply("R7 upper ignored neg", 4'd5, 12'd100, 12'h0FB, 8'h00, 3'd0, 0, 1, 0, 0, 12'd96, 2);
  endtask

  task automatic t_skip_eq();
    apply("R8 eq short", 4'd8, 12'd40, 12'd99, 0, 0, 8'hA5, 8'hA5, 0, 0, 12'd42, 2);
    apply("R8 eq long R11", 4'd8, 12'd40, 12'd99, 0, 0, 8'hA5, 8'hA5, 0, 1, 12'd43, 3);
    apply("R8 ne R11", 4'd8, 12'd40, 12'd99, 0, 0, 8'hA5, 8'hA4, 0, 1, 12'd41, 1);
  endtask

  task automatic t_skip_regbit();
    apply("R9 clr fires", 4'd9, 12'd70, 0, 0, 3'd7, 8'h7F, 0, 8'h80, 0, 12'd72, 2);
    apply("R9 clr no", 4'd9, 12'd70, 0, 0, 3'd7, 8'h80, 0, 8'h00, 0, 12'd71, 1);
    apply("R9 set fires", 4'd10, 12'd70, 0, 0, 3'd3, 8'h08, 0, 0, 1, 12'd73, 3);
    apply("R9 set no", 4'd10, 12'd70, 0, 0, 3'd3, 8'hF7, 0, 8'hFF, 1, 12'd71, 1);
  endtask

  task automatic t_skip_iobit();
    apply("R10 clr fires", 4'd11, 12'd80, 0, 0, 3'd2, 8'hFF, 0, 8'hFB, 1, 12'd83, 3);
    apply("R10 clr no", 4'd11, 12'd80, 0, 0, 3'd2, 8'h00, 0, 8'h04, 0, 12'd81, 1);
    apply("R10 set fires", 4'd12, 12'd80, 0, 0, 3'd0, 8'h00, 0, 8'h01, 0, 12'd82, 2);
    apply("R10 set no", 4'd12, 12'd80, 0, 0, 3'd0, 8'hFF, 0, 8'hFE, 0, 12'd81, 1);
  endtask

  task automatic t_wrap();
    apply("R12 seq wrap", 4'd0, 12'd4095, 0, 0, 0, 0, 1, 0, 0, 12'd0, 1);
    apply("R12 jump wrap", 4'd7, 12'd4090, 12'd10, 0, 0, 0, 1, 0, 0, 12'd5, 2);
    apply("R12 branch under", 4'd6, 12'd2, 12'h07B, 8'h01, 0, 0, 1, 0, 0, 12'd4094, 2);
    apply("R12 skip wrap", 4'd8, 12'd4094, 0, 0, 0, 8'h3, 8'h3, 0, 1, 12'd1, 3);
  endtask

  initial begin
    clear_inputs();
    rst = 1;
    t_reset();
    t_sequential();
    t_bit_branch();
    t_signed();
    t_unsigned();
    t_jump();
    t_offset_mask();
    t_skip_eq();
    t_skip_regbit();
    t_skip_iobit();
    t_wrap();
    @(negedge clk);
    check("R1 after run", out_valid, next_pc, cycles, taken, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule